// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder

This block adds two 32-bit IEEE 754 binary32 operands. It returns the correctly rounded sum and four exception flags: invalid, overflow, underflow and inexact. A caller gets subtraction by inverting bit 31 of the second operand before presenting it. Each operand is sorted into one of six classes: zero, denormal, normal, infinity, quiet NaN or signalling NaN. A pair that contains a NaN, an infinity or a zero is resolved directly. Any other pair goes through an arithmetic path that aligns the significands, adds or subtracts their magnitudes, normalizes the outcome and rounds it.

The block is a two-stage pipeline with no stall and no back-pressure. A new operation may be issued on every clock. The first stage registers the operands and the rounding mode. The second stage classifies, computes and registers the result, so `out_valid` rises exactly two clocks after `in_valid`. The arithmetic path widens each significand by three low bits for guard, round and sticky. During alignment it never loses a set bit shifted out of the smaller operand.

Top module: `fp32_adder`

## Requirements
- R1: For an operation accepted with `in_valid` high at a rising edge, `out_valid` and its result appear after the second following rising edge. While `out_valid` is low, all four flags are low.
- R2: A signalling NaN has exponent field 0xFF, bit 22 clear and a nonzero fraction. If operand A is a signalling NaN, the result is A with bit 22 set, and invalid is raised. Otherwise, if B is a signalling NaN, the result is B with bit 22 set, and invalid is raised.
- R3: If neither operand is a signalling NaN, a quiet NaN in A is returned unchanged. Failing that, a quiet NaN in B is returned unchanged. No flag is raised in either case.
- R4: The sum of two infinities of equal sign is that infinity. Infinities of opposite sign give 0x7FC00000 with invalid raised. An infinity plus any zero or finite value returns the infinity.
- R5: The rounding mode is encoded 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity. Two zeros of equal sign return that zero. Zeros of opposite sign return +0, except under mode 11, which returns -0.
- R6: A zero plus a nonzero finite operand returns the nonzero operand bit-for-bit, with no flag raised.
- R7: For finite nonzero operands of equal sign, the result is the exact sum rounded under the selected mode. A carry out of the significand raises the exponent.
- R8: For finite nonzero operands of differing sign, the result takes the sign of the operand with the larger magnitude. An exact cancellation yields a zero signed as in R5.
- R9: Modes 01, 10 and 11 round a nonexact sum toward zero, toward +infinity and toward -infinity respectively. Mode 00 rounds to nearest, and a tie goes to the even significand.
- R10: Inexact is raised exactly when the rounded finite result differs from the exact sum.
- R11: When the rounded exponent reaches 255, overflow and inexact are raised. The result is then infinity or 0x7F7FFFFF in magnitude, as set by the mode and the sign: infinity under mode 00, the largest finite value under mode 01, and under modes 10 and 11 infinity only in the direction of rounding.
- R12: Denormal operands are added exactly. A result below the normal range is returned as a denormal or as zero. Underflow is raised only together with inexact, so an exact tiny sum leaves both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and mode are presented this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| rnd_mode | input | 2 | Rounding mode (00 nearest-even, 01 zero, 10 +inf, 11 -inf) |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rounded binary32 sum |
| flag_invalid | output | 1 | Invalid operation |
| flag_overflow | output | 1 | Rounded result overflowed |
| flag_underflow | output | 1 | Tiny and inexact result |
| flag_inexact | output | 1 | Result was rounded |

## Verification
On every cycle the assertions check the following:
- the two-cycle latency;
- that the flags stay quiet between results;
- that invalid always comes with a NaN, and that a NaN result carries no arithmetic flags;
- that overflow always comes with inexact and a saturated exponent;
- that underflow implies inexact;
- that an internal exact cancellation surfaces as a zero signed by the mode.

The bench scenarios cover what a property cannot state compactly:
- the bit-exact value of each rounded sum under all four modes;
- the priority order between signalling and quiet NaNs in the two operand positions;
- ties to even;
- the saturation choice on overflow;
- exact denormal sums.

These results are compared against an exact wide-integer model of the sum.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

  localparam int EW = 8;
  localparam int FW = 23;
  localparam int SW = FW + 1;
  localparam int XW = SW + 3;
  localparam int IW = EW + 2;
  localparam logic [IW-1:0] EMAX_FIELD = IW'((1 << EW) - 1);
  localparam logic [31:0] DEFAULT_NAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    CL_ZERO, CL_DENORM, CL_NORMAL, CL_INF, CL_QNAN, CL_SNAN
  } fclass_e;

  typedef struct packed {
    logic          sign;
    logic [EW-1:0] expo;
    logic [FW-1:0] frac;
  } fp_t;

  function automatic fclass_e classify(input fp_t v);
    if (v.expo == '1) begin
      if (v.frac == '0)       return CL_INF;
      else if (v.frac[FW-1])  return CL_QNAN;
      else                    return CL_SNAN;
    end else if (v.expo == '0) begin
      return (v.frac == '0) ? CL_ZERO : CL_DENORM;
    end
    return CL_NORMAL;
  endfunction

  // Right shift that folds every bit leaving the bottom into bit 0.
  function automatic logic [XW-1:0] sticky_shr(input logic [XW-1:0] m,
                                               input logic [IW-1:0] d);
    logic [XW-1:0] r;
    logic          lost;
    if (d >= IW'(XW)) begin
      r = {{(XW-1){1'b0}}, |m};
    end else begin
      r    = m >> d;
      lost = |(m & ~({XW{1'b1}} << d));
      r[0] = r[0] | lost;
    end
    return r;
  endfunction

  function automatic logic [4:0] lead_zeros(input logic [XW-1:0] v);
    logic [4:0] n;
    logic       found;
    n = '0;
    found = 1'b0;
    for (int i = XW - 1; i >= 0; i--) begin
      if (!found && !v[i]) n = n + 5'd1;
      else                 found = 1'b1;
    end
    return n;
  endfunction

  function automatic logic round_inc(input rmode_e rm, input logic sign,
                                     input logic lsb, input logic [2:0] grs);
    case (rm)
      RM_NEAREST: return grs[2] & (grs[1] | grs[0] | lsb);
      RM_ZERO:    return 1'b0;
      RM_UP:      return !sign && (grs != 3'b000);
      default:    return sign && (grs != 3'b000);
    endcase
  endfunction

  function automatic logic [31:0] overflow_value(input rmode_e rm, input logic sign);
    logic to_inf;
    case (rm)
      RM_NEAREST: to_inf = 1'b1;
      RM_ZERO:    to_inf = 1'b0;
      RM_UP:      to_inf = !sign;
      default:    to_inf = sign;
    endcase
    return to_inf ? {sign, 8'hFF, 23'h0} : {sign, 8'hFE, 23'h7F_FFFF};
  endfunction

endpackage

// File: rtl/fpadd_special.sv
module fpadd_special
  import fpadd_pkg::*;
(
  input  fp_t       a,
  input  fp_t       b,
  input  fclass_e   cls_a,
  input  fclass_e   cls_b,
  input  rmode_e    rm,
  output logic      hit,
  output logic [31:0] res,
  output logic      invalid
);
  logic a_fin, b_fin;
  assign a_fin = (cls_a == CL_NORMAL) || (cls_a == CL_DENORM);
  assign b_fin = (cls_b == CL_NORMAL) || (cls_b == CL_DENORM);

  always_comb begin
    hit = 1'b1;
    invalid = 1'b0;
    res = a;
    if (cls_a == CL_SNAN) begin
      res = a | 32'h0040_0000;
      invalid = 1'b1;
    end else if (cls_b == CL_SNAN) begin
      res = b | 32'h0040_0000;
      invalid = 1'b1;
    end else if (cls_a == CL_QNAN) begin
      res = a;
    end else if (cls_b == CL_QNAN) begin
      res = b;
    end else if (cls_a == CL_INF && cls_b == CL_INF) begin
      if (a.sign == b.sign) res = a;
      else begin
        res = DEFAULT_NAN;
        invalid = 1'b1;
      end
    end else if (cls_a == CL_INF) begin
      res = a;
    end else if (cls_b == CL_INF) begin
      res = b;
    end else if (cls_a == CL_ZERO && cls_b == CL_ZERO) begin
      res = (a.sign == b.sign) ? a : {rm == RM_DOWN, 31'h0};
    end else if (cls_a == CL_ZERO) begin
      res = b;
    end else if (cls_b == CL_ZERO) begin
      res = a;
    end else begin
      hit = !(a_fin && b_fin);
    end
  end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
  import fpadd_pkg::*;
(
  input  fp_t         a,
  input  fp_t         b,
  input  rmode_e      rm,
  output logic [31:0] res,
  output logic        overflow,
  output logic        underflow,
  output logic        inexact,
  output logic        ev_cancel,
  output logic        ev_carry
);
  logic [IW-1:0] ea, eb, e_big, e_sml, d, e_n, e_r, lim;
  logic [XW-1:0] ma, mb, m_big, m_sml, m_al, diff, m_n;
  logic [XW:0]   sum;
  logic [SW:0]   rsig;
  logic [SW-1:0] sig;
  logic [4:0]    lz;
  logic          a_big, same, sign, inc, tiny;
  logic [EW-1:0] exp_field;

  always_comb begin
    ea = (a.expo == '0) ? IW'(1) : {2'b00, a.expo};
    eb = (b.expo == '0) ? IW'(1) : {2'b00, b.expo};
    ma = {a.expo != '0, a.frac, 3'b000};
    mb = {b.expo != '0, b.frac, 3'b000};
    a_big = {a.expo, a.frac} >= {b.expo, b.frac};
    e_big = a_big ? ea : eb;
    e_sml = a_big ? eb : ea;
    m_big = a_big ? ma : mb;
    m_sml = a_big ? mb : ma;
    d     = e_big - e_sml;
    m_al  = sticky_shr(m_sml, d);
    same  = (a.sign == b.sign);

    sum  = {1'b0, m_big} + {1'b0, m_al};
    diff = m_big - m_al;
    lz   = lead_zeros(diff);
    lim  = e_big - IW'(1);
    ev_carry  = same && sum[XW];
    ev_cancel = !same && (diff == '0);

    if (same) begin
      if (sum[XW]) begin
        m_n = {sum[XW:2], sum[1] | sum[0]};
        e_n = e_big + IW'(1);
      end else begin
        m_n = sum[XW-1:0];
        e_n = e_big;
      end
      sign = a.sign;
    end else begin
      if ({5'b0, lz} > lim) begin
        m_n = diff << lim;
        e_n = IW'(1);
      end else begin
        m_n = diff << lz;
        e_n = e_big - {5'b0, lz};
      end
      sign = ev_cancel ? (rm == RM_DOWN) : (a_big ? a.sign : b.sign);
    end

    inc  = round_inc(rm, sign, m_n[3], m_n[2:0]);
    rsig = {1'b0, m_n[XW-1:3]} + {{SW{1'b0}}, inc};
    if (rsig[SW]) begin
      sig = rsig[SW:1];
      e_r = e_n + IW'(1);
    end else begin
      sig = rsig[SW-1:0];
      e_r = e_n;
    end
    tiny      = (e_n == IW'(1)) && !m_n[XW-1];
    inexact   = (m_n[2:0] != 3'b000) || (e_r >= EMAX_FIELD);
    overflow  = (e_r >= EMAX_FIELD);
    underflow = tiny && inexact;
    exp_field = sig[SW-1] ? e_r[EW-1:0] : '0;

    if (overflow)       res = overflow_value(rm, sign);
    else if (ev_cancel) res = {sign, 31'h0};
    else                res = {sign, exp_field, sig[FW-1:0]};
  end
endmodule

// File: rtl/fp32_adder.sv
module fp32_adder
  import fpadd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [1:0]  rnd_mode,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_invalid,
  output logic        flag_overflow,
  output logic        flag_underflow,
  output logic        flag_inexact
);
  logic        s1_valid;
  fp_t         s1_opnd [2];
  rmode_e      s1_rm;
  fclass_e     cls [2];

  logic        spec_hit, spec_invalid;
  logic [31:0] spec_res, core_res, sel_res;
  logic        core_ovf, core_unf, core_inx, ev_cancel, ev_carry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_opnd[0] <= '0;
      s1_opnd[1] <= '0;
      s1_rm      <= RM_NEAREST;
    end else begin
      s1_valid   <= in_valid;
      s1_opnd[0] <= op_a;
      s1_opnd[1] <= op_b;
      s1_rm      <= rmode_e'(rnd_mode);
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cls
    assign cls[g] = classify(s1_opnd[g]);
  end

  fpadd_special u_special (
    .a(s1_opnd[0]), .b(s1_opnd[1]), .cls_a(cls[0]), .cls_b(cls[1]),
    .rm(s1_rm), .hit(spec_hit), .res(spec_res), .invalid(spec_invalid)
  );

  fpadd_core u_core (
    .a(s1_opnd[0]), .b(s1_opnd[1]), .rm(s1_rm), .res(core_res),
    .overflow(core_ovf), .underflow(core_unf), .inexact(core_inx),
    .ev_cancel(ev_cancel), .ev_carry(ev_carry)
  );

  assign sel_res = spec_hit ? spec_res : core_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      result         <= '0;
      flag_invalid   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
      flag_inexact   <= 1'b0;
    end else begin
      out_valid      <= s1_valid;
      result         <= s1_valid ? sel_res : '0;
      flag_invalid   <= s1_valid && spec_hit && spec_invalid;
      flag_overflow  <= s1_valid && !spec_hit && core_ovf;
      flag_underflow <= s1_valid && !spec_hit && core_unf;
      flag_inexact   <= s1_valid && !spec_hit && core_inx;
    end
  end
endmodule

// File: rtl/fpadd_checker.sv
module fpadd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flag_invalid,
  input logic        flag_overflow,
  input logic        flag_underflow,
  input logic        flag_inexact,
  input logic        s1_valid,
  input logic [1:0]  s1_rm,
  input logic        spec_hit,
  input logic        ev_cancel
);
  logic res_nan;
  assign res_nan = (result[30:23] == 8'hFF) && (result[22:0] != 23'h0);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  p_flags_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flag_invalid || flag_overflow || flag_underflow || flag_inexact));

  p_invalid_nan_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_invalid) |-> (result[30:22] == 9'h1FF));

  p_nan_quiet_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_nan) |-> !(flag_overflow || flag_underflow || flag_inexact));

  p_cancel_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !spec_hit && ev_cancel) |=>
      (result[30:0] == 31'h0) && (result[31] == $past(s1_rm == 2'b11)));

  p_overflow_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> (flag_inexact && result[30:23] >= 8'hFE));

  p_underflow_inexact_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> flag_inexact);
endmodule

bind fp32_adder fpadd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .result(result), .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
  .flag_underflow(flag_underflow), .flag_inexact(flag_inexact),
  .s1_valid(s1_valid), .s1_rm(s1_rm), .spec_hit(spec_hit), .ev_cancel(ev_cancel)
);

// File: tb/fp32_adder_bench.sv
module fp32_adder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [1:0]  rnd_mode = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_invalid, flag_overflow, flag_underflow, flag_inexact;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] q_res [$];
  logic [3:0]  q_flg [$];
  string       q_tag [$];

  always #5 clk = ~clk;

  fp32_adder u_fp32_adder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .rnd_mode(rnd_mode), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_inexact(flag_inexact)
  );

  function automatic logic is_nan(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0;
  endfunction
  function automatic logic is_inf(input logic [31:0] x);
    return x[30:0] == 31'h7F80_0000;
  endfunction

  // Exact magnitude in units of 2^-149.
  function automatic logic [299:0] mag(input logic [31:0] x);
    logic [299:0] v;
    v = 300'(x[22:0]);
    if (x[30:23] != 0) begin
      v[23] = 1'b1;
      v = v << (int'(x[30:23]) - 1);
    end
    return v;
  endfunction

  // f = {invalid, overflow, underflow, inexact}
  function automatic void ref_add(input logic [31:0] a, input logic [31:0] b,
                                  input logic [1:0] rm,
                                  output logic [31:0] r, output logic [3:0] f);
    logic [299:0] va, vb, m, q, rem, half;
    logic s, up;
    int p, sh, ef;
    f = 4'b0000;
    if (is_nan(a) && !a[22])      begin r = a | 32'h0040_0000; f = 4'b1000; end
    else if (is_nan(b) && !b[22]) begin r = b | 32'h0040_0000; f = 4'b1000; end
    else if (is_nan(a)) r = a;
    else if (is_nan(b)) r = b;
    else if (is_inf(a) && is_inf(b)) begin
      if (a[31] == b[31]) r = a; else begin r = 32'h7FC0_0000; f = 4'b1000; end
    end
    else if (is_inf(a)) r = a;
    else if (is_inf(b)) r = b;
    else begin
      va = mag(a); vb = mag(b);
      if (a[31] == b[31]) begin m = va + vb; s = a[31]; end
      else if (va >= vb)  begin m = va - vb; s = a[31]; end
      else                begin m = vb - va; s = b[31]; end
      if (m == 0) begin
        s = (a[31] == b[31]) ? a[31] : (rm == 2'b11);
        r = {s, 31'h0};
      end else if (va == 0 && a[31] != b[31]) r = b;
      else if (vb == 0 && a[31] != b[31]) r = a;
      else begin
        p = 0;
        for (int i = 0; i < 300; i++) if (m[i]) p = i;
        if (p <= 23) r = {s, m[30:0]};
        else begin
          sh = p - 23;
          q = m >> sh;
          rem = m - (q << sh);
          half = 300'd1 << (sh - 1);
          case (rm)
            2'b00: up = (rem > half) || (rem == half && q[0]);
            2'b01: up = 1'b0;
            2'b10: up = !s && rem != 0;
            default: up = s && rem != 0;
          endcase
          if (up) q = q + 1;
          if (q[24]) begin q = q >> 1; sh = sh + 1; end
          ef = sh + 1;
          f[0] = (rem != 0);
          if (ef >= 255) begin
            f = 4'b0101;
            if (rm == 2'b00 || (rm == 2'b10 && !s) || (rm == 2'b11 && s))
              r = {s, 8'hFF, 23'h0};
            else
              r = {s, 8'hFE, 23'h7F_FFFF};
          end else r = {s, ef[7:0], q[22:0]};
        end
      end
    end
  endfunction

  task automatic send(input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] rm, input string tag);
    logic [31:0] r;
    logic [3:0]  f;
    @(negedge clk);
    op_a = a; op_b = b; rnd_mode = rm; in_valid = 1'b1;
    ref_add(a, b, rm, r, f);
    q_res.push_back(r); q_flg.push_back(f); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        checks++;
        if (q_res.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected out_valid, result=%h expected no output", result);
        end else begin
          logic [31:0] er; logic [3:0] ef; string t;
          er = q_res.pop_front(); ef = q_flg.pop_front(); t = q_tag.pop_front();
          if (result !== er ||
              {flag_invalid, flag_overflow, flag_underflow, flag_inexact} !== ef) begin
            errors++;
            $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b", t,
                     result, {flag_invalid, flag_overflow, flag_underflow, flag_inexact},
                     er, ef);
          end
        end
      end else if (flag_invalid || flag_overflow || flag_underflow || flag_inexact) begin
        checks++;
        errors++;
        $display("FAIL R1: flags=%b while idle, expected 0000",
                 {flag_invalid, flag_overflow, flag_underflow, flag_inexact});
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: cycles=%0d expected under 200000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    logic [8:0]  eb;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 32'h0) begin
      errors++;
      $display("FAIL R1: reset out_valid=%b result=%h expected 0 00000000", out_valid, result);
    end
    rst_n = 1'b1;
    idle(2);

    send(32'h7F80_0001, 32'h7FC0_0000, 2'b00, "R2");
    send(32'h7FC1_2345, 32'hFF80_0005, 2'b00, "R2");
    send(32'h3F80_0000, 32'h7F80_0003, 2'b01, "R2");
    send(32'h7FC0_0042, 32'h3F80_0000, 2'b00, "R3");
    send(32'h3F80_0000, 32'hFFC0_0007, 2'b00, "R3");
    send(32'h7FC0_0011, 32'hFFC0_0022, 2'b10, "R3");
    send(32'h7F80_0000, 32'h7F80_0000, 2'b00, "R4");
    send(32'h7F80_0000, 32'hFF80_0000, 2'b00, "R4");
    send(32'h4040_0000, 32'hFF80_0000, 2'b00, "R4");
    send(32'h0000_0000, 32'h8000_0000, 2'b00, "R5");
    send(32'h0000_0000, 32'h8000_0000, 2'b11, "R5");
    send(32'h8000_0000, 32'h8000_0000, 2'b10, "R5");
    send(32'h0000_0000, 32'h0000_0005, 2'b00, "R6");
    send(32'h3F80_0000, 32'h8000_0000, 2'b11, "R6");
    send(32'h3F80_0000, 32'h3F80_0000, 2'b00, "R7");
    send(32'h3FFF_FFFF, 32'h3FFF_FFFF, 2'b00, "R7");
    send(32'h3F80_0000, 32'hBF80_0000, 2'b00, "R8");
    send(32'h3F80_0000, 32'hBF80_0000, 2'b11, "R8");
    send(32'h3F80_0000, 32'hC040_0000, 2'b00, "R8");
    send(32'h3F80_0000, 32'h3380_0000, 2'b00, "R9");
    send(32'h3F80_0001, 32'h3380_0000, 2'b00, "R9");
    send(32'h3F80_0000, 32'h3380_0001, 2'b01, "R9");
    send(32'h3F80_0000, 32'h3380_0001, 2'b10, "R9");
    send(32'hBF80_0000, 32'hB380_0001, 2'b11, "R9");
    send(32'h3F80_0000, 32'h0000_0001, 2'b10, "R10");
    send(32'h3F80_0000, 32'hB300_0000, 2'b00, "R10");
    send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'b00, "R11");
    send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'b01, "R11");
    send(32'h7F7F_FFFF, 32'h7F7F_FFFF, 2'b11, "R11");
    send(32'hFF7F_FFFF, 32'hFF7F_FFFF, 2'b11, "R11");
    send(32'h7F7F_FFFF, 32'h7380_0000, 2'b10, "R11");
    send(32'h0040_0000, 32'h0040_0000, 2'b00, "R12");
    send(32'h0000_0003, 32'h8000_0001, 2'b00, "R12");
    send(32'h0080_0000, 32'h8000_0001, 2'b00, "R12");
    send(32'h0080_0001, 32'h8080_0000, 2'b11, "R12");
    idle(3);

    for (int n = 0; n < 4000; n++) begin
      ra = $urandom;
      rb = $urandom;
      if (n % 4 != 0) begin
        eb = {1'b0, ra[30:23]} + 9'($urandom_range(0, 30)) - 9'd15;
        rb[30:23] = eb[8] ? 8'h00 : eb[7:0];
      end
      if (n % 16 == 1) ra[30:23] = 8'h00;
      send(ra, rb, 2'($urandom_range(0, 3)), (ra[31] == rb[31]) ? "R7" : "R8");
    end
    idle(5);

    checks++;
    if (q_res.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0", q_res.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule